// File: doc/BRIEF.md
# Serial Wiper Register Controller

This block is the serial slave control logic for a single digitally controlled potentiometer. It keeps a 6-bit wiper position that selects one of 64 taps and a bank of four 6-bit storage slots that stand in for nonvolatile memory. The slots are held in ordinary flops, and a busy timer models the write time of real storage. A host talks to the block over a four-wire SPI-style link: chip select, serial clock, serial data in and serial data out. The block drives a tap code to the resistor array and an output-enable for the serial data pin.

Every transaction begins with chip select falling. The first byte must carry the device code in its upper nibble, and the second byte is a command. The commands cover direct reads and writes of the wiper and of the slots, copies in both directions between a slot and the wiper, a stepping mode in which every further data bit moves the wiper by one tap, and a status read that reports whether a storage write is still running. At reset the wiper takes the value of slot 0.

All SPI pins are brought into the system clock domain through synchronisers, and the block acts on the edges it detects there. The serial clock must therefore run well below the system clock.

Top module: `spi_wiper_ctrl`

## Requirements
- R1: After reset the wiper output equals the reset value of slot 0 (40 with default parameters) and so_oe is low.
- R2: so_oe is low whenever chip select is high and during every non-read transaction. It is high only in the data phase of a read command.
- R3: A transaction whose first byte has an upper nibble other than 0101 is ignored in full; the wiper and the slots keep their values.
- R4: Command nibble 1010 followed by a data byte loads data bits [5:0] into the wiper once the eighth data bit is taken; data bits [7:6] are ignored.
- R5: Command nibble 1001 returns {2'b00, wiper} on so as one byte, MSB first. so changes after falling SCK edges and is valid for the host to sample at the rising edges.
- R6: Command nibble 1100, with the slot number in command bits [1:0], followed by a data byte, stores data bits [5:0] into that slot when chip select rises. Command nibble 1011 with the same select returns {2'b00, slot}.
- R7: Command nibble 1101 copies the selected slot into the wiper as soon as the command byte is complete.
- R8: Command nibble 1110 copies the wiper into the selected slot when chip select rises.
- R9: After command nibble 0010, each further bit clocked in on si moves the wiper by one tap: a 1 moves it up and a 0 moves it down. The mode lasts until chip select rises.
- R10: Stepping saturates: stepping up at tap 63 leaves 63, and stepping down at tap 0 leaves 0.
- R11: Command nibble 0101 returns a status byte whose bit 0 is the write-busy flag and whose other bits are 0. The flag is 1 for BUSY_CYCLES clock cycles after a storage write starts.
- R12: Storage write commands (1100 and 1110) that arrive while the busy flag is set have no effect on any slot.
- R13: A command byte with an undefined nibble is ignored, and a data byte cut short by chip select rising before its eighth bit is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select from the host |
| sck | input | 1 | Serial clock from the host, idle low |
| si | input | 1 | Serial data from the host |
| so | output | 1 | Serial data to the host |
| so_oe | output | 1 | Output enable for the serial data pin |
| wiper | output | 6 | Tap code driven to the resistor array |

## Verification
A wrong wiper register shows at the wiper port within a few system clocks of the SCK edge that should have moved it. Corrupted slot contents stay hidden until a read or a copy into the wiper exposes them, so the bench reads the slots back after each storage write and after each blocked write. A stuck or short busy timer shows only through the status byte, and the bench reads that byte both inside and after the busy window. Errors in the shift or bit-count path show as a shifted or wrong read byte in the same transaction.

// File: rtl/wpr_pkg.sv
package wpr_pkg;

  localparam logic [3:0] ID_CODE    = 4'b0101;
  localparam logic [3:0] OP_RD_WIP  = 4'b1001;
  localparam logic [3:0] OP_WR_WIP  = 4'b1010;
  localparam logic [3:0] OP_RD_SLOT = 4'b1011;
  localparam logic [3:0] OP_WR_SLOT = 4'b1100;
  localparam logic [3:0] OP_SLOT2W  = 4'b1101;
  localparam logic [3:0] OP_W2SLOT  = 4'b1110;
  localparam logic [3:0] OP_STEP    = 4'b0010;
  localparam logic [3:0] OP_STATUS  = 4'b0101;

  typedef enum logic [2:0] {
    ST_ID,
    ST_CMD,
    ST_WDATA,
    ST_READ,
    ST_STEP,
    ST_SKIP
  } wpr_state_e;

endpackage

// File: rtl/wpr_sync.sv
module wpr_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= {STAGES{RST_VAL}};
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/wpr_nv_timer.sv
module wpr_nv_timer #(
  parameter int CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);

  localparam int CNT_W = $clog2(CYCLES + 1);

  logic [CNT_W-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (start)             cnt_n = CNT_W'(CYCLES);
    else if (cnt_q != '0)  cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign busy = (cnt_q != '0);

  // R11
  busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

  // R11
  busy_countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/wpr_slot_bank.sv
module wpr_slot_bank #(
  parameter int W = 6,
  parameter int N = 4,
  parameter logic [N*W-1:0] RESET = '0,
  localparam int SEL_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [SEL_W-1:0] wsel,
  input  logic [W-1:0]     wdata,
  input  logic [SEL_W-1:0] rsel,
  output logic [W-1:0]     rdata
);

  logic [N-1:0][W-1:0] slot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) slot_q[i] <= RESET[i*W +: W];
    end else if (we) begin
      for (int i = 0; i < N; i++)
        if (wsel == SEL_W'(i)) slot_q[i] <= wdata;
    end
  end

  assign rdata = slot_q[rsel];

  // R12
  slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(slot_q));

endmodule

// File: rtl/spi_wiper_ctrl.sv
module spi_wiper_ctrl
  import wpr_pkg::*;
#(
  parameter int WIPER_W = 6,
  parameter int NUM_SLOTS = 4,
  parameter int BUSY_CYCLES = 1000,
  parameter int SYNC_STAGES = 2,
  parameter logic [NUM_SLOTS*WIPER_W-1:0] SLOT_RESET = {6'd48, 6'd32, 6'd16, 6'd40}
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               sck,
  input  logic               si,
  output logic               so,
  output logic               so_oe,
  output logic [WIPER_W-1:0] wiper
);

  localparam int SEL_W = $clog2(NUM_SLOTS);
  localparam logic [WIPER_W-1:0] TAP_MAX = {WIPER_W{1'b1}};

  // synchronised pins and edge detection
  logic cs_s, sck_s, si_s, cs_q, sck_q;
  logic sck_rise, sck_fall, cs_rise;

  wpr_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n, sck, si}), .q({cs_s, sck_s, si_s})
  );

  assign sck_rise = sck_s & ~sck_q;
  assign sck_fall = ~sck_s & sck_q;
  assign cs_rise  = cs_s & ~cs_q;

  // control state
  wpr_state_e state_q, state_n;
  logic [2:0] bit_q, bit_n;
  logic [6:0] shin_q, shin_n;
  logic [7:0] shout_q, shout_n;
  logic [3:0] op_q, op_n;
  logic [SEL_W-1:0] sel_q, sel_n;
  logic loaded_q, loaded_n;
  logic [WIPER_W-1:0] wiper_q, wiper_n;
  logic pend_q, pend_n;
  logic [SEL_W-1:0] psel_q, psel_n;
  logic [WIPER_W-1:0] pval_q, pval_n;

  logic [7:0] byte_full, rd_byte;
  logic [SEL_W-1:0] rsel;
  logic [WIPER_W-1:0] slot_rd;
  logic nv_start, nv_busy, last_bit;

  assign byte_full = {shin_q, si_s};
  assign last_bit  = (bit_q == 3'd7);
  assign rsel      = (state_q == ST_CMD) ? byte_full[SEL_W-1:0] : sel_q;
  assign nv_start  = cs_rise & pend_q;

  wpr_slot_bank #(.W(WIPER_W), .N(NUM_SLOTS), .RESET(SLOT_RESET)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(nv_start), .wsel(psel_q), .wdata(pval_q),
    .rsel(rsel), .rdata(slot_rd)
  );

  wpr_nv_timer #(.CYCLES(BUSY_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(nv_start), .busy(nv_busy)
  );

  always_comb begin
    case (op_q)
      OP_RD_WIP:  rd_byte = 8'(wiper_q);
      OP_RD_SLOT: rd_byte = 8'(slot_rd);
      default:    rd_byte = {7'd0, nv_busy};
    endcase
  end

  always_comb begin
    state_n  = state_q;
    bit_n    = bit_q;
    shin_n   = shin_q;
    shout_n  = shout_q;
    op_n     = op_q;
    sel_n    = sel_q;
    loaded_n = loaded_q;
    wiper_n  = wiper_q;
    pend_n   = pend_q;
    psel_n   = psel_q;
    pval_n   = pval_q;
    if (cs_rise) pend_n = 1'b0;
    if (cs_s) begin
      state_n  = ST_ID;
      bit_n    = 3'd0;
      loaded_n = 1'b0;
    end else begin
      if (sck_rise) begin
        shin_n = byte_full[6:0];
        bit_n  = bit_q + 3'd1;
        case (state_q)
          ST_ID: if (last_bit) state_n = (byte_full[7:4] == ID_CODE) ? ST_CMD : ST_SKIP;
          ST_CMD: if (last_bit) begin
            op_n    = byte_full[7:4];
            sel_n   = byte_full[SEL_W-1:0];
            state_n = ST_SKIP;
            case (byte_full[7:4])
              OP_RD_WIP, OP_RD_SLOT, OP_STATUS: state_n = ST_READ;
              OP_WR_WIP:  state_n = ST_WDATA;
              OP_WR_SLOT: if (!nv_busy) state_n = ST_WDATA;
              OP_SLOT2W:  wiper_n = slot_rd;
              OP_W2SLOT: if (!nv_busy) begin
                pend_n = 1'b1;
                psel_n = byte_full[SEL_W-1:0];
                pval_n = wiper_q;
              end
              OP_STEP: state_n = ST_STEP;
              default: ;
            endcase
          end
          ST_WDATA: if (last_bit) begin
            state_n = ST_SKIP;
            if (op_q == OP_WR_WIP) begin
              wiper_n = byte_full[WIPER_W-1:0];
            end else begin
              pend_n = 1'b1;
              psel_n = sel_q;
              pval_n = byte_full[WIPER_W-1:0];
            end
          end
          ST_STEP: begin
            if (si_s) wiper_n = (wiper_q == TAP_MAX) ? TAP_MAX : wiper_q + 1'b1;
            else      wiper_n = (wiper_q == '0) ? '0 : wiper_q - 1'b1;
          end
          default: ;
        endcase
      end
      if (sck_fall && state_q == ST_READ) begin
        loaded_n = 1'b1;
        shout_n  = loaded_q ? {shout_q[6:0], 1'b0} : rd_byte;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q     <= 1'b1;
      sck_q    <= 1'b0;
      state_q  <= ST_ID;
      bit_q    <= 3'd0;
      shin_q   <= '0;
      shout_q  <= '0;
      op_q     <= '0;
      sel_q    <= '0;
      loaded_q <= 1'b0;
      wiper_q  <= SLOT_RESET[WIPER_W-1:0];
      pend_q   <= 1'b0;
      psel_q   <= '0;
      pval_q   <= '0;
    end else begin
      cs_q     <= cs_s;
      sck_q    <= sck_s;
      state_q  <= state_n;
      bit_q    <= bit_n;
      shin_q   <= shin_n;
      shout_q  <= shout_n;
      op_q     <= op_n;
      sel_q    <= sel_n;
      loaded_q <= loaded_n;
      wiper_q  <= wiper_n;
      pend_q   <= pend_n;
      psel_q   <= psel_n;
      pval_q   <= pval_n;
    end
  end

  assign so    = shout_q[7];
  assign so_oe = (state_q == ST_READ);
  assign wiper = wiper_q;

  // R2
  oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> !so_oe);

  // R3
  wiper_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wiper_q) |-> !$past(cs_s));

  // R10
  step_sat_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STEP && !cs_s && sck_rise && si_s && wiper_q == TAP_MAX) |=> (wiper_q == TAP_MAX));

  // R10
  step_sat_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STEP && !cs_s && sck_rise && !si_s && wiper_q == '0) |=> (wiper_q == '0));

  // R12
  nv_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nv_start |-> !nv_busy);

endmodule

// File: tb/tb_spi_wiper_ctrl.sv
module tb_spi_wiper_ctrl;

  localparam int HP = 8;
  localparam int BUSY = 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sck = 1'b0;
  logic si = 1'b0;
  logic so, so_oe;
  logic [5:0] wiper;

  always #2.5 clk = ~clk;

  spi_wiper_ctrl #(.BUSY_CYCLES(BUSY)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .so(so), .so_oe(so_oe), .wiper(wiper)
  );

  int n_chk = 0;
  int n_bad = 0;
  string exp_tag[$];
  int exp_val[$];
  int act_val[$];
  logic [7:0] tx_buf [8];
  logic [7:0] rx_buf [8];
  logic oe_seen;

  // driver side: expected items
  task automatic expect_item(input string tag, input int val);
    exp_tag.push_back(tag);
    exp_val.push_back(val);
  endtask

  // observed results
  task automatic observe(input int val);
    act_val.push_back(val);
  endtask

  // monitor: pops and compares
  initial forever begin
    @(posedge clk);
    while (act_val.size() > 0 && exp_val.size() > 0) begin
      automatic string t = exp_tag.pop_front();
      automatic int e = exp_val.pop_front();
      automatic int a = act_val.pop_front();
      n_chk++;
      if (a != e) begin
        n_bad++;
        $display("FAIL %s: actual %0d expected %0d", t, a, e);
      end
    end
  end

  task automatic hp_wait(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_txn(input int nbits);
    oe_seen = 1'b0;
    cs_n = 1'b0;
    hp_wait(HP);
    for (int i = 0; i < nbits; i++) begin
      si = tx_buf[i/8][7 - (i % 8)];
      hp_wait(HP);
      rx_buf[i/8][7 - (i % 8)] = so;
      if (i == 16) oe_seen = so_oe;
      sck = 1'b1;
      hp_wait(HP);
      sck = 1'b0;
    end
    hp_wait(HP);
    cs_n = 1'b1;
    hp_wait(4 * HP);
  endtask

  task automatic txn3(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
    tx_buf[0] = b0; tx_buf[1] = b1; tx_buf[2] = b2;
    run_txn(24);
  endtask

  task automatic txn2(input logic [7:0] b0, input logic [7:0] b1);
    tx_buf[0] = b0; tx_buf[1] = b1;
    run_txn(16);
  endtask

  task automatic check_read(input string tag, input logic [7:0] b1, input int val);
    expect_item(tag, val);
    txn3(8'h50, b1, 8'h00);
    observe(int'(rx_buf[2]));
  endtask

  task automatic check_wiper(input string tag, input int val);
    expect_item(tag, val);
    observe(int'(wiper));
  endtask

  initial begin
    hp_wait(5);
    rst_n = 1'b1;
    hp_wait(5);

    // R1 reset state
    check_wiper("R1 wiper after reset", 40);
    expect_item("R1 so_oe after reset", 0);
    observe(int'(so_oe));

    // R5 read wiper, R2 output enable during read data
    check_read("R5 read wiper", 8'h90, 40);
    expect_item("R2 so_oe during read data", 1);
    observe(int'(oe_seen));
    expect_item("R2 so_oe with cs high", 0);
    observe(int'(so_oe));

    // R4 write wiper, upper data bits ignored
    txn3(8'h50, 8'hA0, 8'hD5);
    check_wiper("R4 write wiper", 21);
    expect_item("R2 so_oe in write", 0);
    observe(int'(oe_seen));

    // R3 bad device code
    txn3(8'h70, 8'hA0, 8'h3F);
    check_wiper("R3 bad id ignored", 21);

    // R7 slot 2 to wiper
    txn2(8'h50, 8'hD2);
    check_wiper("R7 slot to wiper", 32);

    // R6 write slot 3, R11 busy, R12 blocked write
    txn3(8'h50, 8'hC3, 8'h07);
    check_read("R11 status busy", 8'h50, 1);
    txn3(8'h50, 8'hC1, 8'h22);
    hp_wait(BUSY + 100);
    check_read("R11 status idle", 8'h50, 0);
    check_read("R6 read slot 3", 8'hB3, 7);
    check_read("R12 slot 1 unchanged", 8'hB1, 16);

    // R8 wiper to slot 0
    txn2(8'h50, 8'hE0);
    hp_wait(BUSY + 100);
    check_read("R8 read slot 0", 8'hB0, 32);

    // R9 / R10 stepping
    txn3(8'h50, 8'hA0, 8'h3D);
    txn3(8'h50, 8'h20, 8'hFF);
    check_wiper("R10 saturate at top", 63);
    txn3(8'h50, 8'h20, 8'hF0);
    check_wiper("R9 step pattern", 59);
    txn3(8'h50, 8'h20, 8'hAA);
    check_wiper("R9 alternating steps", 59);
    txn3(8'h50, 8'hA0, 8'h02);
    txn3(8'h50, 8'h20, 8'h00);
    check_wiper("R10 saturate at bottom", 0);

    // R13 undefined opcode, truncated data byte
    txn3(8'h50, 8'h30, 8'hFF);
    check_wiper("R13 undefined opcode", 0);
    tx_buf[0] = 8'h50; tx_buf[1] = 8'hA0; tx_buf[2] = 8'h3F;
    run_txn(20);
    check_wiper("R13 truncated data", 0);
    check_read("R13 read after truncation", 8'h90, 0);

    hp_wait(10);
    if (exp_val.size() != 0) begin
      n_chk++;
      n_bad++;
      $display("FAIL scoreboard: actual %0d left expected 0", exp_val.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule